// File: doc/BRIEF.md
# Self-Clocked Converter Serial Output Sequencer

This block is the device end of a three-wire serial link in which the device makes the shift clock itself. A counter stands in for the converter core. While the core converts, the sequencer holds both the clock pin and the data pin high. When the result is ready it pulls both pins low, which tells the host that the conversion is done. After a short pause it sends a burst of exactly nineteen clock pulses. On this burst it sends the result frame on the data pin and reads a channel-select command from the host data input. A new conversion then starts, and the cycle repeats with no chip-select activity.

A power-on timer runs first. It counts a fixed number of system cycles once the supply-good input is high. At the end of that count it samples the level on the clock pin. If the pin is high, the sequencer uses the self-clocked mode. If something outside holds the pin low, the sequencer records external clock mode, stops driving the pin and runs no frames. All timing is counted in system clock cycles: the power-on delay, the conversion time and the half period of the generated clock.

Top module: `adc_selfclk_port`

## Requirements
- R1: `por_done` rises after exactly `POR_CYC` consecutive cycles with `supply_ok` high. A low cycle on `supply_ok` restarts the count. `sck_oe` stays 0 until `por_done` is 1, and `por_done` never falls again before reset.
- R2: The mode is latched from `sck_pad_in` in the cycle the power-on count ends. A level of 1 gives `int_mode`=1. A level of 0 gives `int_mode`=0; in that case `sck_oe` stays 0, `sdo` stays 1 and `cmd_valid` never pulses.
- R3: Each conversion shows `sck_o`=1 and `sdo`=1 for exactly `CONV_CYC` cycles. It is counted from the first cycle with `sck_oe`=1, or from the cycle where `cmd_valid` pulses.
- R4: At the end of a conversion, `sck_o` and `sdo` fall together in the same cycle. Both stay low for exactly `HALF_CYC` cycles before the first rising edge of the clock.
- R5: Each frame has exactly 19 rising edges on `sck_o`. Every high phase and every low phase lasts `HALF_CYC` cycles, except the final high phase, which runs straight into the next conversion.
- R6: The values of `sdo` at rises 1 to 19 are, in order: 0 (end-of-conversion flag), 0 (a filler bit), the sign, then the 16-bit result from MSB to LSB.
- R7: `sdo` changes only in cycles where `sck_o` falls, with one exception: at the end of the 19th high phase it returns to 1 while `sck_o` stays 1. It never changes on a rising edge.
- R8: `sdi` is sampled at rises 1 to `CMD_W`, and the first sample becomes the MSB of `cmd_word`. Values of `sdi` at later rises are ignored. `cmd_word` updates with a one-cycle `cmd_valid` pulse in the first cycle of the next conversion.
- R9: The frame carries the `res_sign`/`res_data` values present in the last cycle of the conversion. Changes to those inputs during the frame do not alter it.
- R10: Conversions and frames repeat without end in self-clocked mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-good indication that starts the power-on count |
| sck_pad_in | input | 1 | Level seen on the clock pin, used for mode detection |
| sdi | input | 1 | Serial command input from the host |
| res_data | input | RES_W | Value the converter stub captures |
| res_sign | input | 1 | Sign the converter stub captures |
| sck_o | output | 1 | Generated shift clock level |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdo | output | 1 | Serial data and end-of-conversion flag |
| por_done | output | 1 | Power-on period complete |
| int_mode | output | 1 | 1 = self-clocked mode latched, 0 = external clock mode |
| cmd_word | output | CMD_W | Last command captured from `sdi` |
| cmd_valid | output | 1 | One-cycle strobe when `cmd_word` updates |

## Verification
A wrong phase or rise count shows at the pins within one clock half period: the low run before a rise has the wrong length, or `cmd_valid` arrives before or after the 19th rise. A wrong bit index or a stale result register shows up in the next frame, because its nineteen samples no longer match the expected sign and data word. A bad shift in the command path shows in `cmd_word` at that frame's end. A bad power-on count or a wrong mode latch is caught in the cycle `por_done` rises, or in the first cycle where `sck_oe` would be driven.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

   typedef enum logic [2:0] {
      SQ_POR   = 3'd0,
      SQ_EXT   = 3'd1,
      SQ_CONV  = 3'd2,
      SQ_SLEEP = 3'd3,
      SQ_HI    = 3'd4,
      SQ_LO    = 3'd5
   } sq_state_t;

   // number of non-data bits that lead every frame: flag, filler, sign
   localparam int unsigned HDR_BITS = 3;

endpackage

// File: rtl/adcq_por_mode.sv
module adcq_por_mode #(
   parameter int unsigned POR_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic sck_pad_in,
   output logic por_done,
   output logic int_mode
);

   logic done_q;
   logic mode_q;
   logic fin;

   generate
      if (POR_CYC <= 1) begin : g_imm
         assign fin = supply_ok && !done_q;
      end else begin : g_cnt
         localparam int unsigned PW = $clog2(POR_CYC + 1);
         logic [PW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!supply_ok || done_q) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign fin = supply_ok && !done_q && (cnt_q == PW'(POR_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         mode_q <= 1'b0;
      end else if (fin) begin
         done_q <= 1'b1;
         mode_q <= sck_pad_in;
      end
   end

   assign por_done = done_q;
   assign int_mode = mode_q;

endmodule

// File: rtl/adcq_conv_stub.sv
module adcq_conv_stub #(
   parameter int unsigned CONV_CYC = 2000,
   parameter int unsigned RES_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [RES_W-1:0] res_data,
   input  logic             res_sign,
   output logic             done,
   output logic [RES_W-1:0] res_q,
   output logic             sign_q
);

   localparam int unsigned CW = $clog2(CONV_CYC + 1);

   logic [CW-1:0] cnt_q;

   assign done = go && (cnt_q == CW'(CONV_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!go || done) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         sign_q <= 1'b0;
      end else if (done) begin
         res_q  <= res_data;
         sign_q <= res_sign;
      end
   end

endmodule

// File: rtl/adcq_frame_seq.sv
module adcq_frame_seq
   import adcq_pkg::*;
#(
   parameter int unsigned HALF_CYC = 4,
   parameter int unsigned RES_W    = 16,
   parameter int unsigned CMD_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_done,
   input  logic             int_mode,
   input  logic             conv_done,
   input  logic [RES_W-1:0] res_q,
   input  logic             sign_q,
   input  logic             sdi,
   output logic             conv_go,
   output logic             sck_o,
   output logic             sck_oe,
   output logic             sdo,
   output logic [CMD_W-1:0] cmd_word,
   output logic             cmd_valid
);

   localparam int unsigned FRAME_LEN = RES_W + HDR_BITS;
   localparam int unsigned HW        = $clog2(HALF_CYC + 1);
   localparam int unsigned RW        = $clog2(FRAME_LEN + 1);
   localparam logic [HW-1:0] PH_LAST = HW'(HALF_CYC - 1);
   localparam logic [RW-1:0] RISE_END = RW'(FRAME_LEN);
   localparam logic [RW-1:0] CAP_END  = RW'(CMD_W);

   sq_state_t st_q, st_d;
   logic [HW-1:0]      ph_q, ph_d;
   logic [RW-1:0]      rise_q, rise_d;
   logic               sck_q, sck_d;
   logic               sdo_q, sdo_d;
   logic               oe_q, oe_d;
   logic [CMD_W-1:0]   cap_q, cap_d;
   logic [CMD_W-1:0]   cmd_q, cmd_d;
   logic               vld_q, vld_d;
   logic [FRAME_LEN-1:0] frame_w;
   logic               ph_end;

   // flag (0) and filler (0) lead the sign and the data word
   assign frame_w = {1'b0, 1'b0, sign_q, res_q};
   assign ph_end  = (ph_q == PH_LAST);

   function automatic logic pick_bit(input logic [FRAME_LEN-1:0] f,
                                     input logic [RW-1:0] done_rises);
      int unsigned pos;
      pos = FRAME_LEN - 1 - int'(done_rises);
      return f[pos];
   endfunction

   always_comb begin
      st_d   = st_q;
      ph_d   = ph_q;
      rise_d = rise_q;
      sck_d  = sck_q;
      sdo_d  = sdo_q;
      oe_d   = oe_q;
      cap_d  = cap_q;
      cmd_d  = cmd_q;
      vld_d  = 1'b0;
      unique case (st_q)
         SQ_POR: begin
            if (por_done) begin
               if (int_mode) begin
                  st_d  = SQ_CONV;
                  sck_d = 1'b1;
                  sdo_d = 1'b1;
                  oe_d  = 1'b1;
               end else begin
                  st_d = SQ_EXT;
               end
            end
         end
         SQ_EXT: begin
            st_d = SQ_EXT;
         end
         SQ_CONV: begin
            if (conv_done) begin
               st_d  = SQ_SLEEP;
               sck_d = 1'b0;
               sdo_d = 1'b0;
               ph_d  = '0;
            end
         end
         SQ_SLEEP: begin
            if (ph_end) begin
               st_d   = SQ_HI;
               sck_d  = 1'b1;
               rise_d = RW'(1);
               ph_d   = '0;
               cap_d  = {cap_q[CMD_W-2:0], sdi};
            end else begin
               ph_d = ph_q + 1'b1;
            end
         end
         SQ_HI: begin
            if (ph_end) begin
               ph_d = '0;
               if (rise_q == RISE_END) begin
                  st_d  = SQ_CONV;
                  sdo_d = 1'b1;
                  cmd_d = cap_q;
                  vld_d = 1'b1;
               end else begin
                  st_d  = SQ_LO;
                  sck_d = 1'b0;
                  sdo_d = pick_bit(frame_w, rise_q);
               end
            end else begin
               ph_d = ph_q + 1'b1;
            end
         end
         SQ_LO: begin
            if (ph_end) begin
               st_d   = SQ_HI;
               sck_d  = 1'b1;
               ph_d   = '0;
               rise_d = rise_q + 1'b1;
               if (rise_q < CAP_END) begin
                  cap_d = {cap_q[CMD_W-2:0], sdi};
               end
            end else begin
               ph_d = ph_q + 1'b1;
            end
         end
         default: begin
            st_d = SQ_POR;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_POR;
         ph_q   <= '0;
         rise_q <= '0;
         sck_q  <= 1'b1;
         sdo_q  <= 1'b1;
         oe_q   <= 1'b0;
         cap_q  <= '0;
         cmd_q  <= '0;
         vld_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         rise_q <= rise_d;
         sck_q  <= sck_d;
         sdo_q  <= sdo_d;
         oe_q   <= oe_d;
         cap_q  <= cap_d;
         cmd_q  <= cmd_d;
         vld_q  <= vld_d;
      end
   end

   assign conv_go   = (st_q == SQ_CONV);
   assign sck_o     = sck_q;
   assign sck_oe    = oe_q;
   assign sdo       = sdo_q;
   assign cmd_word  = cmd_q;
   assign cmd_valid = vld_q;

endmodule

// File: rtl/adc_selfclk_port.sv
module adc_selfclk_port #(
   parameter int unsigned POR_CYC  = 100000,
   parameter int unsigned CONV_CYC = 2000,
   parameter int unsigned HALF_CYC = 4,
   parameter int unsigned RES_W    = 16,
   parameter int unsigned CMD_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             sck_pad_in,
   input  logic             sdi,
   input  logic [RES_W-1:0] res_data,
   input  logic             res_sign,
   output logic             sck_o,
   output logic             sck_oe,
   output logic             sdo,
   output logic             por_done,
   output logic             int_mode,
   output logic [CMD_W-1:0] cmd_word,
   output logic             cmd_valid
);

   localparam int unsigned FRAME_LEN = RES_W + adcq_pkg::HDR_BITS;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (CONV_CYC < 2) begin : g_bad_conv
         $error("CONV_CYC must be at least 2");
      end
      if (CMD_W < 2 || CMD_W > FRAME_LEN) begin : g_bad_cmd
         $error("CMD_W must lie between 2 and the frame length");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("RES_W must be at least 1");
      end
   endgenerate

   logic             conv_go;
   logic             conv_done;
   logic [RES_W-1:0] res_q;
   logic             sign_q;

   adcq_por_mode #(
      .POR_CYC (POR_CYC)
   ) u_por (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_ok  (supply_ok),
      .sck_pad_in (sck_pad_in),
      .por_done   (por_done),
      .int_mode   (int_mode)
   );

   adcq_conv_stub #(
      .CONV_CYC (CONV_CYC),
      .RES_W    (RES_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (conv_go),
      .res_data (res_data),
      .res_sign (res_sign),
      .done     (conv_done),
      .res_q    (res_q),
      .sign_q   (sign_q)
   );

   adcq_frame_seq #(
      .HALF_CYC (HALF_CYC),
      .RES_W    (RES_W),
      .CMD_W    (CMD_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_done  (por_done),
      .int_mode  (int_mode),
      .conv_done (conv_done),
      .res_q     (res_q),
      .sign_q    (sign_q),
      .sdi       (sdi),
      .conv_go   (conv_go),
      .sck_o     (sck_o),
      .sck_oe    (sck_oe),
      .sdo       (sdo),
      .cmd_word  (cmd_word),
      .cmd_valid (cmd_valid)
   );

endmodule

// File: rtl/adcq_chk.sv
module adcq_chk #(
   parameter int unsigned FRAME_LEN = 19
) (
   input logic clk,
   input logic rst_n,
   input logic por_done,
   input logic int_mode,
   input logic sck_o,
   input logic sck_oe,
   input logic sdo,
   input logic cmd_valid
);

   localparam int unsigned RW = $clog2(FRAME_LEN + 2);

   logic          prev_sck;
   logic [RW-1:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sck <= 1'b1;
         rises    <= '0;
      end else begin
         prev_sck <= sck_o;
         if (cmd_valid) begin
            rises <= '0;
         end else if (sck_oe && sck_o && !prev_sck) begin
            rises <= rises + 1'b1;
         end
      end
   end

   // R1
   oe_before_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !por_done |-> !sck_oe);

   // R1
   por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_done |=> por_done);

   // R2
   ext_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (por_done && !int_mode) |-> (!sck_oe && sdo && !cmd_valid));

   // R5
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (rises == RW'(FRAME_LEN)));

   // R5
   rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rises <= RW'(FRAME_LEN));

   // R7
   sdo_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && $past(sck_oe) && $rose(sck_o)) |-> $stable(sdo));

   // R7
   sdo_fall_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && $fell(sdo)) |-> !sck_o);

   // R8
   cmd_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (sck_o && sdo && sck_oe));

endmodule

bind adc_selfclk_port adcq_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .por_done  (por_done),
   .int_mode  (int_mode),
   .sck_o     (sck_o),
   .sck_oe    (sck_oe),
   .sdo       (sdo),
   .cmd_valid (cmd_valid)
);

// File: tb/adc_selfclk_port_tb.sv
module adc_selfclk_port_tb;

   localparam int unsigned POR_CYC  = 50;
   localparam int unsigned CONV_CYC = 40;
   localparam int unsigned HALF_CYC = 3;
   localparam int unsigned RES_W    = 16;
   localparam int unsigned CMD_W    = 6;
   localparam int unsigned FL       = RES_W + 3;
   localparam int unsigned N_FRAMES = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             supply_ok = 1'b0;
   logic             sck_pad_in = 1'b1;
   logic             sdi = 1'b0;
   logic [RES_W-1:0] res_data = '0;
   logic             res_sign = 1'b0;
   logic             sck_o, sck_oe, sdo, por_done, int_mode, cmd_valid;
   logic [CMD_W-1:0] cmd_word;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   adc_selfclk_port #(
      .POR_CYC (POR_CYC), .CONV_CYC (CONV_CYC), .HALF_CYC (HALF_CYC),
      .RES_W (RES_W), .CMD_W (CMD_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok),
      .sck_pad_in (sck_pad_in), .sdi (sdi), .res_data (res_data),
      .res_sign (res_sign), .sck_o (sck_o), .sck_oe (sck_oe), .sdo (sdo),
      .por_done (por_done), .int_mode (int_mode), .cmd_word (cmd_word),
      .cmd_valid (cmd_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [FL-1:0] exp_frame_f(input logic s,
                                                 input logic [RES_W-1:0] d);
      return {1'b0, 1'b0, s, d};
   endfunction

   function automatic logic [RES_W:0] dir_val(input int i);
      case (i)
         0: return {1'b0, 16'h0000};
         1: return {1'b1, 16'hFFFF};
         2: return {1'b0, 16'h8000};
         3: return {1'b1, 16'h0001};
         default: return {1'($urandom), 16'($urandom)};
      endcase
   endfunction

   // frame monitor state
   bit              mon_en = 0;
   bit              in_frame = 0;
   bit              prev_s = 1, prev_d = 1, prev_oe = 0;
   int              conv_cnt = 0, low_cnt = 0, hi_cnt = 0, rises = 0;
   int              frames = 0;
   logic [FL-1:0]   rx = '0;
   logic [FL-1:0]   exp_fr = '0;
   logic [CMD_W-1:0] exp_cmd = '0;

   always @(negedge clk) begin
      if (mon_en) begin
         if (cmd_valid) begin
            chk(rises == FL, "R5", "rises per frame", rises, FL);
            chk(rx == exp_fr, "R6/R9", "frame bits", rx, exp_fr);
            chk(cmd_word == exp_cmd, "R8", "cmd_word", cmd_word, exp_cmd);
            chk(sck_o && sdo, "R7", "pins at frame end", {sck_o, sdo}, 2'b11);
            in_frame = 0;
            conv_cnt = 1;
            frames++;
            exp_cmd = CMD_W'($urandom);
         end else if (sck_oe && !prev_oe) begin
            conv_cnt = 1;
         end else if (!in_frame && sck_o && sdo) begin
            conv_cnt++;
         end else if (!in_frame && !sck_o && !sdo && prev_s && prev_d) begin
            chk(conv_cnt == CONV_CYC, "R3", "conversion length", conv_cnt, CONV_CYC);
            in_frame = 1;
            rises = 0;
            low_cnt = 1;
            rx = '0;
            exp_fr = exp_frame_f(res_sign, res_data);
         end else if (in_frame) begin
            if (sck_o && !prev_s) begin
               if (rises == 0)
                  chk(low_cnt == HALF_CYC, "R4", "sleep length", low_cnt, HALF_CYC);
               else
                  chk(low_cnt == HALF_CYC, "R5", "low phase", low_cnt, HALF_CYC);
               chk(sdo == prev_d, "R7", "sdo at rise", sdo, prev_d);
               rx = {rx[FL-2:0], sdo};
               rises++;
               hi_cnt = 1;
               if (rises == 1) begin
                  // R9: move the inputs during the frame
                  {res_sign, res_data} = dir_val(frames + 1);
               end
            end else if (!sck_o && prev_s) begin
               chk(hi_cnt == HALF_CYC, "R5", "high phase", hi_cnt, HALF_CYC);
               low_cnt = 1;
            end else if (sck_o) begin
               hi_cnt++;
            end else begin
               low_cnt++;
            end
         end
         // command bits: MSB first for rises 1..CMD_W, junk afterwards (R8)
         if (sck_oe && !sck_o) begin
            if (rises < CMD_W) sdi = exp_cmd[CMD_W-1-rises];
            else sdi = 1'($urandom);
         end
         prev_s = sck_o;
         prev_d = sdo;
         prev_oe = sck_oe;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'h5EED_0042));
      exp_cmd = 6'b101101;
      {res_sign, res_data} = dir_val(0);
      repeat (3) @(negedge clk);
      // reset state
      chk(!por_done && !sck_oe && sdo && !cmd_valid, "R1", "reset outputs",
          {por_done, sck_oe, sdo, cmd_valid}, 4'b0010);
      rst_n = 1'b1;
      @(negedge clk);
      supply_ok = 1'b1;
      repeat (20) @(negedge clk);
      chk(!por_done, "R1", "early por_done", por_done, 0);
      supply_ok = 1'b0;
      @(negedge clk);
      supply_ok = 1'b1;
      n = 0;
      mon_en = 1;
      while (!por_done && n < 1000) begin
         @(negedge clk);
         n++;
         if (!por_done) chk(!sck_oe, "R1", "sck_oe before por", sck_oe, 0);
      end
      chk(n == POR_CYC, "R1", "por count", n, POR_CYC);
      chk(int_mode == 1'b1, "R2", "internal mode latched", int_mode, 1);
      while (frames < N_FRAMES) @(negedge clk);
      chk(frames == N_FRAMES, "R10", "repeated frames", frames, N_FRAMES);

      // external mode: pin held low when the power-on count ends
      mon_en = 0;
      rst_n = 1'b0;
      supply_ok = 1'b0;
      sck_pad_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      supply_ok = 1'b1;
      n = 0;
      while (!por_done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(n == POR_CYC, "R1", "por count ext", n, POR_CYC);
      chk(int_mode == 1'b0, "R2", "external mode latched", int_mode, 0);
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            sdi = 1'($urandom);
            if (sck_oe || !sdo || cmd_valid) bad++;
         end
         chk(bad == 0, "R2", "parked in external mode", bad, 0);
      end
      finish_run();
   end

endmodule